// File: doc/BRIEF.md
# Condition-Field Compare Unit

This block evaluates one comparison per accepted request and records the outcome in a 4-bit field of an internal 32-bit condition register that holds eight such fields. The second operand is either a 64-bit register value or a 16-bit immediate. A width select restricts the comparison to the low 32-bit words. In that case each word is sign-extended or zero-extended first, according to the signed/unsigned select. A separate byte-match mode asks a different question: does the low byte of the first operand equal any of the eight bytes of the second operand?

A 3-bit index selects the field to write. The other seven fields keep their contents, so a series of compares can build up a full condition word. The field contents are, from the most significant bit down: less-than, greater-than, equal, and a copy of the summary-overflow input. The updated register appears one clock after a valid request. A synchronous reset clears it.

Top module: `cfcmp_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets `cr_o` to 0x00000000.
- R2: With `byte_match`=0, `is_signed`=1 and `wide`=1, the operands are compared as 64-bit two's-complement numbers. The written field is {LT, GT, EQ, SO}, with LT at the field's most significant bit, and exactly one of LT/GT/EQ is set.
- R3: With `byte_match`=0, `is_signed`=0 and `wide`=1, the operands are compared as 64-bit unsigned numbers, using the same field layout as R2.
- R4: With `wide`=0, the upper 32 bits of both operands are ignored. The low words are sign-extended when `is_signed`=1 and zero-extended otherwise, so 0xffffffffaaaaaaaa and 0x00000000aaaaaaaa compare equal. Zero compared unsigned against 0xffff6dc1 gives LT.
- R5: With `use_imm`=1, `imm` replaces `opb`. It is zero-extended for unsigned compares and sign-extended for signed compares.
- R6: In compare modes, bit 0 of the written field equals `so_flag`.
- R7: With `byte_match`=1, the field becomes 4'b0100 if `opa[7:0]` equals any byte of `opb`, and 4'b0000 otherwise. `is_signed`, `wide`, `use_imm`, `imm` and `so_flag` have no effect in this mode.
- R8: Field n occupies `cr_o[31-4n -: 4]` (field 0 is bits 31:28). Only the field selected by `field_idx` changes. For example, writing LT with SO clear into field 7 of 0x35055050 gives 0x35055058.
- R9: The result of a request with `in_valid`=1 appears on `cr_o` after the next rising edge. While `in_valid`=0, `cr_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand (register form) |
| imm | input | 16 | Immediate second operand |
| use_imm | input | 1 | Select `imm` instead of `opb` |
| wide | input | 1 | 1: 64-bit compare, 0: low 32-bit words |
| is_signed | input | 1 | 1: signed compare, 0: unsigned |
| byte_match | input | 1 | Byte-match mode |
| so_flag | input | 1 | Summary-overflow bit copied into the field |
| field_idx | input | 3 | Target field number |
| cr_o | output | 32 | Condition register |

## Verification
Operand narrowing and immediate extension can act on the same request. A signed 32-bit compare against an immediate whose bit 15 is set must extend the immediate and then treat its low word as negative. The sweep drives every pairing of width, signedness and immediate use over operands whose sign bits differ between bit 15, bit 31 and bit 63. Each result is judged against a bench model that computes the field arithmetically and tracks all eight fields, so a wrong field or a disturbed neighbour is also caught.

// File: rtl/cfcmp_pkg.sv
package cfcmp_pkg;
    localparam int NFIELD  = 8;
    localparam int FIELD_W = 4;
    localparam int CR_W    = NFIELD * FIELD_W;

    typedef struct packed {
        logic [CR_W-1:0] cr;
    } cfcmp_state_t;
endpackage

// File: rtl/cfcmp_operand_prep.sv
module cfcmp_operand_prep #(
    parameter int DW   = 64,
    parameter int IMMW = 16
) (
    input  logic [DW-1:0]   opa,
    input  logic [DW-1:0]   opb,
    input  logic [IMMW-1:0] imm,
    input  logic            use_imm,
    input  logic            wide,
    input  logic            is_signed,
    output logic [DW-1:0]   a_ext,
    output logic [DW-1:0]   b_ext
);
    localparam int HALF = DW / 2;

    logic [DW-1:0] b_sel;
    logic          imm_fill;

    always_comb begin
        imm_fill = is_signed & imm[IMMW-1];
        b_sel    = use_imm ? {{(DW-IMMW){imm_fill}}, imm} : opb;
        if (wide) begin
            a_ext = opa;
            b_ext = b_sel;
        end else begin
            a_ext = {{HALF{is_signed & opa[HALF-1]}}, opa[HALF-1:0]};
            b_ext = {{HALF{is_signed & b_sel[HALF-1]}}, b_sel[HALF-1:0]};
        end
    end
endmodule

// File: rtl/cfcmp_magnitude.sv
module cfcmp_magnitude #(
    parameter int DW = 64
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          is_signed,
    output logic          lt,
    output logic          gt,
    output logic          eq
);
    always_comb begin
        eq = (a == b);
        if (is_signed) begin
            lt = $signed(a) < $signed(b);
        end else begin
            lt = a < b;
        end
        gt = !lt && !eq;
    end
endmodule

// File: rtl/cfcmp_byte_match.sv
module cfcmp_byte_match #(
    parameter int DW  = 64,
    parameter int BYW = 8
) (
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    output logic          hit
);
    localparam int NBYTES = DW / BYW;

    logic [NBYTES-1:0] lane_hit;

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign lane_hit[g] = (opa[BYW-1:0] == opb[g*BYW +: BYW]);
    end

    assign hit = |lane_hit;
endmodule

// File: rtl/cfcmp_unit.sv
module cfcmp_unit
    import cfcmp_pkg::*;
#(
    parameter int DW   = 64,
    parameter int IMMW = 16,
    parameter int BYW  = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [DW-1:0]             opa,
    input  logic [DW-1:0]             opb,
    input  logic [IMMW-1:0]           imm,
    input  logic                      use_imm,
    input  logic                      wide,
    input  logic                      is_signed,
    input  logic                      byte_match,
    input  logic                      so_flag,
    input  logic [$clog2(NFIELD)-1:0] field_idx,
    output logic [CR_W-1:0]           cr_o
);
    localparam int IDXW = $clog2(NFIELD);

    cfcmp_state_t         st_d, st_q;
    logic [DW-1:0]        a_ext, b_ext;
    logic                 rel_lt, rel_gt, rel_eq;
    logic                 bm_hit;
    logic [FIELD_W-1:0]   field_new;

    cfcmp_operand_prep #(.DW(DW), .IMMW(IMMW)) prep_i (
        .opa(opa), .opb(opb), .imm(imm), .use_imm(use_imm),
        .wide(wide), .is_signed(is_signed), .a_ext(a_ext), .b_ext(b_ext)
    );

    cfcmp_magnitude #(.DW(DW)) mag_i (
        .a(a_ext), .b(b_ext), .is_signed(is_signed),
        .lt(rel_lt), .gt(rel_gt), .eq(rel_eq)
    );

    cfcmp_byte_match #(.DW(DW), .BYW(BYW)) bm_i (
        .opa(opa), .opb(opb), .hit(bm_hit)
    );

    always_comb begin
        st_d = st_q;
        if (byte_match) begin
            field_new = {1'b0, bm_hit, 2'b00};
        end else begin
            field_new = {rel_lt, rel_gt, rel_eq, so_flag};
        end
        if (in_valid) begin
            for (int f = 0; f < NFIELD; f++) begin
                if (field_idx == IDXW'(f)) begin
                    st_d.cr[CR_W-1-f*FIELD_W -: FIELD_W] = field_new;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cr_o = st_q.cr;
endmodule

// File: rtl/cfcmp_unit_checker.sv
module cfcmp_unit_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        byte_match,
    input logic        so_flag,
    input logic [2:0]  field_idx,
    input logic [31:0] cr_o
);
    function automatic logic [31:0] sel_mask(input logic [2:0] idx);
        return 32'hF000_0000 >> (4 * idx);
    endfunction

    function automatic logic [3:0] nib(input logic [31:0] cr, input logic [2:0] idx);
        return 4'((cr >> (28 - 4 * idx)) & 32'hF);
    endfunction

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cr_o == 32'h0));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(cr_o));

    assert_other_fields_R8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ((cr_o & ~sel_mask($past(field_idx))) ==
                      ($past(cr_o) & ~sel_mask($past(field_idx)))));

    // R2 and R3: exactly one relation bit in compare modes
    assert_one_relation_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !byte_match) |=>
            ($countones(nib(cr_o, $past(field_idx)) & 4'b1110) == 1));

    assert_so_copy_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !byte_match) |=> (nib(cr_o, $past(field_idx))[0] == $past(so_flag)));

    assert_bytematch_bits_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && byte_match) |=> ((nib(cr_o, $past(field_idx)) & 4'b1011) == 4'b0000));
endmodule

bind cfcmp_unit cfcmp_unit_checker chk_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .byte_match(byte_match),
    .so_flag(so_flag), .field_idx(field_idx), .cr_o(cr_o)
);

// File: tb/cfcmp_unit_tb_top.sv
module cfcmp_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] opa = '0, opb = '0;
    logic [15:0] imm = '0;
    logic        use_imm = 1'b0, wide = 1'b1, is_signed = 1'b0;
    logic        byte_match = 1'b0, so_flag = 1'b0;
    logic [2:0]  field_idx = '0;
    logic [31:0] cr_o;

    int errors = 0;
    int checks = 0;
    logic [31:0] model = '0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    cfcmp_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .opa(opa), .opb(opb),
        .imm(imm), .use_imm(use_imm), .wide(wide), .is_signed(is_signed),
        .byte_match(byte_match), .so_flag(so_flag), .field_idx(field_idx),
        .cr_o(cr_o)
    );

    function automatic logic [3:0] ref_field(
        input logic [63:0] a, input logic [63:0] b, input logic [15:0] im,
        input logic ui, input logic wd, input logic sg, input logic bm, input logic so);
        logic [63:0] aa, bb;
        logic lt, eq;
        if (bm) begin
            logic hit;
            hit = 1'b0;
            for (int k = 0; k < 8; k++) if (a[7:0] == b[8*k +: 8]) hit = 1'b1;
            return {1'b0, hit, 2'b00};
        end
        bb = ui ? (sg ? 64'($signed(im)) : {48'h0, im}) : b;
        aa = a;
        if (!wd) begin
            aa = sg ? 64'($signed(a[31:0]))  : {32'h0, a[31:0]};
            bb = sg ? 64'($signed(bb[31:0])) : {32'h0, bb[31:0]};
        end
        eq = (aa == bb);
        lt = sg ? (longint'(aa) < longint'(bb)) : (aa < bb);
        return {lt, !lt && !eq, eq, so};
    endfunction

    task automatic check(input string req, input logic [31:0] exp);
        checks++;
        if (cr_o !== exp) begin
            errors++;
            $display("FAIL %s: cr_o=%08h expected=%08h", req, cr_o, exp);
        end
    endtask

    task automatic do_op(input string req, input logic [63:0] a, input logic [63:0] b,
                         input logic [15:0] im, input logic ui, input logic wd,
                         input logic sg, input logic bm, input logic so, input logic [2:0] idx);
        @(negedge clk);
        opa = a; opb = b; imm = im; use_imm = ui; wide = wd; is_signed = sg;
        byte_match = bm; so_flag = so; field_idx = idx; in_valid = 1'b1;
        model[31-4*idx -: 4] = ref_field(a, b, im, ui, wd, sg, bm, so);
        @(negedge clk);
        in_valid = 1'b0;
        check(req, model);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    logic [63:0] vals [10];

    initial begin
        vals[0] = 64'h0;
        vals[1] = 64'h1;
        vals[2] = 64'hffffffffaaaaaaaa;
        vals[3] = 64'h00000000aaaaaaaa;
        vals[4] = 64'h8000000000000000;
        vals[5] = 64'h7fffffffffffffff;
        vals[6] = 64'h00000000ffff6dc1;
        vals[7] = 64'h00000000301f7a9c;
        vals[8] = 64'h0001030507090b0f;
        vals[9] = 64'h12345678_9abc8000;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", 32'h0);

        // R4 directed: equal low words, zero below 0xffff6dc1
        do_op("R4", vals[2], vals[3], 16'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd2);
        do_op("R4", vals[0], vals[6], 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1);
        // R5 directed: unsigned immediate 0x8000 is larger than 0x7fff
        do_op("R5", 64'h7fff, 64'h0, 16'h8000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd3);
        // R6 directed: SO copied
        do_op("R6", vals[5], vals[4], 16'h0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 3'd4);

        // R8: build 0x35055050 then write LT into field 7
        do_op("R8", 64'h5, 64'h5, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 3'd0);
        do_op("R8", 64'h2, 64'h1, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 3'd1);
        do_op("R8", 64'h0, 64'h1111111111111111, 16'h0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd2);
        do_op("R8", 64'h2, 64'h1, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 3'd3);
        do_op("R8", 64'h2, 64'h1, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 3'd4);
        do_op("R8", 64'h0, 64'h1111111111111111, 16'h0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd5);
        do_op("R8", 64'h2, 64'h1, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 3'd6);
        do_op("R8", 64'h0, 64'h1111111111111111, 16'h0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd7);
        check("R8", 32'h35055050);
        do_op("R8", vals[0], vals[6], 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd7);
        check("R8", 32'h35055058);

        // R7 directed: byte hit in top byte, SO and sign ignored
        do_op("R7", 64'hffffffffffffff00, 64'h00ffffffffffffff, 16'hffff, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 3'd5);

        // R9: idle cycles with busy inputs leave the register unchanged
        @(negedge clk);
        opa = vals[4]; opb = vals[5]; field_idx = 3'd7; byte_match = 1'b0; so_flag = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check("R9", model);
        end

        // sweep
        begin
            int n;
            n = 0;
            for (int i = 0; i < 10; i++) begin
                for (int j = 0; j < 10; j++) begin
                    for (int m = 0; m < 32; m++) begin
                        string tag;
                        logic ui, wd, sg, bm, so;
                        ui = m[0]; wd = m[1]; sg = m[2]; bm = m[3]; so = m[4];
                        if (bm)       tag = "R7";
                        else if (ui)  tag = "R5";
                        else if (!wd) tag = "R4";
                        else if (sg)  tag = "R2";
                        else          tag = "R3";
                        do_op(tag, vals[i], vals[j], vals[j][15:0], ui, wd, sg, bm, so, 3'(n));
                        n++;
                    end
                end
            end
        end

        // R1: reset after activity
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model = '0;
        check("R1", 32'h0);

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            finish_run();
        end
    end
endmodule